// File: doc/BRIEF.md
# Multi-Channel PWM Controller with Buffered Updates

This block generates four independent pulse-width modulated outputs, configured over a simple register bus with address, write data, write strobe and read data. Software starts and stops channels through two write-one-to-act bitmask registers and reads the running state back from a status register. Each channel has a mode register, a duty register, a period register and an update register.

Each channel divides the input clock by a power of two, then counts 0 to period−1 and wraps. The output is active while the count is below duty, and a mode bit can invert it. A stopped channel accepts direct duty and period writes. A running channel ignores those writes and takes new values only through its update register. The pending value is moved into duty or period when the counter wraps, so the waveform never shows a partial period.

Top module: `pwm_bank`

## Requirements
- R1: A write to address 0x04 sets the running bit of every channel n whose data bit n is 1. Zero bits leave channels unchanged. A read of 0x0C returns the running bits in bits 3:0 and zero above them.
- R2: A write to address 0x08 stops every channel n whose data bit n is 1. Zero bits leave channels unchanged.
- R3: Channel n's registers are at 0x200 + n×0x20, with mode at +0x00, duty at +0x04, period at +0x08 and update at +0x10. In mode, bits 3:0 are the prescaler, bit 9 is polarity and bit 10 is the update target. All other mode bits read as zero.
- R4: Duty and period store only the low 16 bits of a write, and their upper 16 bits read as zero.
- R5: A running channel's counter advances once every 2^pres clocks from 0 to period−1 and then wraps to 0. A period of 0 behaves as 1. The output is high while the counter is less than duty, so duty 0 gives constant low and duty ≥ period gives constant high.
- R6: With mode bit 9 set, the channel output is the inverse of the R5 waveform.
- R7: A stopped channel holds its counter at 0 and drives its output to the inactive level, which is low for normal polarity and high for inverted polarity. Starting it restarts the waveform from count 0.
- R8: Duty and period writes take effect immediately on a stopped channel and are ignored on a running one.
- R9: A write to the update register stores a pending value. The value is copied into duty when mode bit 10 is 0, or into period when it is 1, only when the running counter wraps. The pending state is cleared at that copy.
- R10: Prescaler values above 10 act as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pwm_out | output | 4 | Channel outputs |

## Verification
The assertions assume one bus access per cycle. They also assume that a channel's period changes only while the channel is stopped or at a wrap, which the register rules enforce. The bounds check on the counter depends on that.

The bench drives each access for a single cycle between falling edges and never writes enable and disable in the same cycle. It sweeps prescaler, period, duty, polarity and channel over small ranges. It compares every sampled output against the count formula from R5.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH  = 4,
  parameter int CW   = 16,
  parameter int AW   = 12,
  parameter int PMAX = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int CIW       = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int CH_BASE   = 'h200;
  localparam int CH_STRIDE = 'h20;
  localparam int CH_END    = CH_BASE + NCH * CH_STRIDE;
  localparam logic [AW-1:0] A_ENA  = AW'('h04);
  localparam logic [AW-1:0] A_DIS  = AW'('h08);
  localparam logic [AW-1:0] A_STAT = AW'('h0C);

  logic [NCH-1:0] run;
  logic [3:0]     pres [NCH];
  logic           pol  [NCH];
  logic           tgt  [NCH];
  logic [CW-1:0]  duty [NCH];
  logic [CW-1:0]  per  [NCH];
  logic [CW-1:0]  updv [NCH];
  logic           pend [NCH];
  logic [CW-1:0]  cnt  [NCH];
  logic [PMAX-1:0] pcnt [NCH];

  logic [AW-1:0]  chrel;
  logic           in_ch;
  logic [CIW-1:0] ch_idx;
  logic [4:0]     ch_off;

  assign chrel  = bus_addr - AW'(CH_BASE);
  assign in_ch  = (int'(bus_addr) >= CH_BASE) && (int'(bus_addr) < CH_END);
  assign ch_idx = chrel[5 +: CIW];
  assign ch_off = chrel[4:0];

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (bus_we && bus_addr == A_ENA) run <= run | bus_wdata[NCH-1:0];
    else if (bus_we && bus_addr == A_DIS) run <= run & ~bus_wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic            sel, wr_mode, wr_duty, wr_per, wr_upd, tick, last;
    logic [3:0]      pe;
    logic [PMAX-1:0] mask;

    assign sel     = bus_we && in_ch && ch_idx == CIW'(i);
    assign wr_mode = sel && ch_off == 5'h00;
    assign wr_duty = sel && ch_off == 5'h04;
    assign wr_per  = sel && ch_off == 5'h08;
    assign wr_upd  = sel && ch_off == 5'h10;
    assign pe      = (int'(pres[i]) > PMAX) ? 4'(PMAX) : pres[i];
    assign mask    = PMAX'((32'd1 << pe) - 32'd1);
    assign tick    = (pcnt[i] & mask) == mask;
    assign last    = ({1'b0, cnt[i]} + 1'b1) >= {1'b0, per[i]};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pres[i] <= '0; pol[i] <= 1'b0; tgt[i] <= 1'b0;
        duty[i] <= '0; per[i] <= '0; updv[i] <= '0; pend[i] <= 1'b0;
        cnt[i]  <= '0; pcnt[i] <= '0;
      end else begin
        if (wr_mode) begin
          pres[i] <= bus_wdata[3:0];
          pol[i]  <= bus_wdata[9];
          tgt[i]  <= bus_wdata[10];
        end
        if (!run[i]) begin
          cnt[i]  <= '0;
          pcnt[i] <= '0;
          if (wr_duty) duty[i] <= bus_wdata[CW-1:0];
          if (wr_per)  per[i]  <= bus_wdata[CW-1:0];
        end else begin
          pcnt[i] <= pcnt[i] + 1'b1;
          if (tick) begin
            if (last) begin
              cnt[i] <= '0;
              if (pend[i]) begin
                if (tgt[i]) per[i] <= updv[i];
                else        duty[i] <= updv[i];
                pend[i] <= 1'b0;
              end
            end else begin
              cnt[i] <= cnt[i] + 1'b1;
            end
          end
        end
        if (wr_upd) begin
          updv[i] <= bus_wdata[CW-1:0];
          pend[i] <= 1'b1;
        end
      end
    end

    assign pwm_out[i] = pol[i] ^ (run[i] && (cnt[i] < duty[i]));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT) bus_rdata = 32'(run);
    for (int i = 0; i < NCH; i++) begin
      if (in_ch && ch_idx == CIW'(i)) begin
        case (ch_off)
          5'h00:   bus_rdata = 32'(pres[i]) | (32'(pol[i]) << 9) | (32'(tgt[i]) << 10);
          5'h04:   bus_rdata = 32'(duty[i]);
          5'h08:   bus_rdata = 32'(per[i]);
          5'h10:   bus_rdata = 32'(updv[i]);
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_we,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] run,
  input logic           pol [NCH],
  input logic [CW-1:0]  cnt [NCH],
  input logic [CW-1:0]  per [NCH]
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h04)) |=>
      ((run & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  assert_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h04)) |=> ((run & $past(run)) == $past(run)));

  assert_stat_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'('h0C)) |-> (bus_rdata[31:NCH] == '0));

  assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'('h08)) |=> ((run & $past(bus_wdata[NCH-1:0])) == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |-> (pwm_out[i] == pol[i]));
    assert_idle_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |=> (cnt[i] == '0));
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[i] == '0) || (cnt[i] < per[i]));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (.*);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  pwm_bank i_pwm_bank (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 12'(a); bus_we = 1'b0;
    #1 v = bus_rdata;
  endtask

  function automatic int chb(input int ch);
    return 'h200 + ch * 'h20;
  endfunction

  function automatic bit model(input int i, input int pres, input int p, input int d, input bit pl);
    int pe = (pres > 10) ? 10 : pres;
    int pp = (p == 0) ? 1 : p;
    int c = (i >> pe) % pp;
    return pl ^ (c < d);
  endfunction

  task automatic run_cfg(input int ch, input int pres, input int p, input int d,
                         input bit pl, input int n, input string req);
    int bad = 0;
    bit expv = 1'b0, actv = 1'b0;
    wr('h08, 32'(1 << ch));
    wr(chb(ch), 32'(pres) | (32'(pl) << 9));
    wr(chb(ch) + 4, 32'(d));
    wr(chb(ch) + 8, 32'(p));
    wr('h04, 32'(1 << ch));
    for (int i = 0; i < n; i++) begin
      if (pwm_out[ch] !== model(i, pres, p, d, pl) && bad == 0) begin
        actv = pwm_out[ch]; expv = model(i, pres, p, d, pl);
      end
      if (pwm_out[ch] !== model(i, pres, p, d, pl)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, req, longint'(actv), longint'(expv));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd('h0C, v); chk(v == 0, "R1 reset status", v, 0);
    chk(pwm_out == 4'b0, "R7 reset outputs", pwm_out, 0);

    wr(chb(2), 32'hFFFF_F605);
    rd(chb(2), v); chk(v == 32'h605, "R3 mode fields", v, 32'h605);
    wr(chb(2), 0);
    wr(chb(2) + 4, 32'hABCD_1234);
    rd(chb(2) + 4, v); chk(v == 32'h1234, "R4 duty width", v, 32'h1234);
    wr(chb(2) + 8, 32'h8765_4321);
    rd(chb(2) + 8, v); chk(v == 32'h4321, "R4 period width", v, 32'h4321);

    // R5 R6 R3 sweep over channel, prescaler, period, duty, polarity
    for (int pres = 0; pres < 3; pres++)
      for (int p = 0; p < 6; p++)
        for (int d = 0; d < 7; d++)
          for (int pl = 0; pl < 2; pl++) begin
            run_cfg(k % 4, pres, p, d, pl[0], 2 * ((p == 0) ? 1 : p) * (1 << pres) + 3,
                    pl ? "R6 inverted waveform" : "R5 waveform");
            k++;
          end
    wr('h08, 32'hF);

    // R10 prescaler clamp
    run_cfg(3, 12, 2, 1, 1'b0, 2200, "R10 prescaler clamp");
    wr('h08, 32'hF);

    // R7 restart from zero
    run_cfg(0, 0, 5, 2, 1'b0, 3, "R7 first run");
    wr('h08, 32'h1);
    chk(pwm_out[0] == 1'b0, "R7 stopped level", pwm_out[0], 0);
    wr('h04, 32'h1);
    begin
      int bad = 0;
      for (int i = 0; i < 12; i++) begin
        if (pwm_out[0] !== model(i, 0, 5, 2, 1'b0)) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R7 restart", bad, 0);
    end

    // R1 R2 zero bits ignored
    wr('h04, 32'h2);
    rd('h0C, v); chk(v == 32'h3, "R1 zero bits keep", v, 3);
    wr('h08, 32'h1);
    rd('h0C, v); chk(v == 32'h2, "R2 stop one", v, 2);
    wr('h08, 32'h2);
    wr(chb(0), 32'h200);
    rd(chb(0), v);
    chk(pwm_out[0] == 1'b1, "R7 inverted idle", pwm_out[0], 1);

    // R8 R9 buffered updates on channel 1
    wr(chb(1), 32'h2);
    wr(chb(1) + 4, 32'h1);
    wr(chb(1) + 8, 32'h4);
    wr('h04, 32'h2);
    wr(chb(1) + 'h10, 32'h3);
    rd(chb(1) + 4, v); chk(v == 1, "R9 held before wrap", v, 1);
    repeat (20) @(negedge clk);
    rd(chb(1) + 4, v); chk(v == 3, "R9 duty after wrap", v, 3);
    wr(chb(1), 32'h402);
    wr(chb(1) + 'h10, 32'h6);
    repeat (40) @(negedge clk);
    rd(chb(1) + 8, v); chk(v == 6, "R9 period after wrap", v, 6);
    wr(chb(1) + 4, 32'h9);
    rd(chb(1) + 4, v); chk(v == 3, "R8 running duty ignored", v, 3);
    wr(chb(1) + 8, 32'h2);
    rd(chb(1) + 8, v); chk(v == 6, "R8 running period ignored", v, 6);
    wr('h08, 32'h2);
    wr(chb(1) + 4, 32'h5);
    rd(chb(1) + 4, v); chk(v == 5, "R8 stopped duty direct", v, 5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule